// File: doc/BRIEF.md
# Switch State Register With Change Interrupt

This block models one switch (a two-position or multi-valued control) as a small register target on a request/response bus. It holds a state word, a flag noting that the state changed and has not yet been acknowledged, an interrupt enable bit, and a build-time direction. Hardware updates the state through a strobe port. Software reads the state and a capability flag, sets or clears the enable, and acknowledges a change by reading the status register. When the switch is built as an output, software may also write the state. A write to the state of an input switch is refused and latches a sticky fault pin.

The single level interrupt is high exactly while a change is pending and the enable is set. Toggling the enable while a change waits therefore moves the line straight to the new enable value. Reading the status acknowledges a change only when interrupts are enabled; with the enable clear, the read returns 0 and leaves the change pending.

Requests use a valid/ready channel and read responses a second valid/ready channel. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Each accepted read yields one response on the next cycle. A response that is not taken holds `rsp_valid` and `rsp_data` steady and drops `req_ready` until `rsp_ready` is seen. Writes produce no response.

Top module: `switch_irq_reg`

## Requirements
- R1: While and after reset, the state is 0, no change is pending, the enable is 0, `irq` is low and `wr_fault` is low.
- R2: A cycle with `upd_valid` high stores `upd_state` (visible on `state_o` the next cycle) and marks a change pending, even if the value is the same; `irq` rises the next cycle if the enable is set.
- R3: A write to the enable register (offset 3) keeps only bit 0 of the write data; reading offset 3 returns that bit with all upper bits 0.
- R4: While a change is pending, an enable write moves `irq` to the new enable value on the next cycle. With nothing pending, enable writes leave `irq` low.
- R5: A read of the status register (offset 2) returns 1 when a change is pending and the enable is set, and in that case clears the pending change so `irq` falls the next cycle. Otherwise it returns 0 and the pending change survives (a later enable write still raises `irq`).
- R6: A read of the flags register (offset 1) returns 1 in bit 0 when the switch is built as an output (`IS_OUTPUT`=1) and 0 when it is built as an input.
- R7: On an output switch, a write to the state register (offset 0) with a value different from the current state stores it and marks a change pending like a hardware update. A write of the same value changes nothing.
- R8: On an input switch, a state write leaves the state unchanged, marks nothing pending and sets `wr_fault`, which stays high until reset.
- R9: When a hardware update and an accepted status read fall in the same cycle, the read reports the old pending condition, and the update wins: the change stays pending afterwards.
- R10: An accepted read gives `rsp_valid` on the next cycle. While `rsp_valid` is high and `rsp_ready` low, `rsp_valid` and `rsp_data` hold and `req_ready` is low.
- R11: Offsets 4 and above read as 0 and ignore writes; reading offset 0 returns the state word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_valid | input | 1 | Hardware state update strobe |
| upd_state | input | DATA_W | New state from hardware |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request accepted this cycle when high with valid |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Register offset (word index) |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response taken |
| rsp_data | output | DATA_W | Read data |
| state_o | output | DATA_W | Current switch state for the hardware side |
| irq | output | 1 | Level interrupt |
| wr_fault | output | 1 | Sticky flag: state write to an input switch |

## Verification
The bench goes after the enable toggled with a change pending and with none pending: a design that latched the interrupt instead of tracking the enable would leave `irq` high after the enable drops. It reads the status with the enable clear and then enables, so a design that cleared the change on every status read would never raise `irq`. It also collides an update with a status read, writes the same state value back, writes the state of an input-built instance, and stalls a read response. The wrong designs would then lose a change, report a change that never happened, corrupt the state, or let a response drift before it is taken.

// File: rtl/sw_pkg.sv
package sw_pkg;
  // Register offsets (word index); the status read and state write behaviour keys on these.
  localparam int unsigned OFF_STATE  = 0;
  localparam int unsigned OFF_FLAGS  = 1;
  localparam int unsigned OFF_STATUS = 2;
  localparam int unsigned OFF_ENABLE = 3;

  typedef enum logic [1:0] {
    SEL_STATE  = 2'd0,
    SEL_FLAGS  = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_ENABLE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic     hit;
    reg_sel_e sel;
  } reg_dec_t;

  function automatic reg_dec_t decode_off(input int unsigned off);
    reg_dec_t d;
    d.hit = 1'b1;
    unique case (off)
      OFF_STATE:  d.sel = SEL_STATE;
      OFF_FLAGS:  d.sel = SEL_FLAGS;
      OFF_STATUS: d.sel = SEL_STATUS;
      OFF_ENABLE: d.sel = SEL_ENABLE;
      default: begin
        d.hit = 1'b0;
        d.sel = SEL_STATE;
      end
    endcase
    return d;
  endfunction
endpackage

// File: rtl/sw_bus_if.sv
module sw_bus_if
  import sw_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  input  logic [DATA_W-1:0] cur_state,
  input  logic              flag_output,
  input  logic              stat_bit,
  input  logic              en_bit,
  output logic              state_wr,
  output logic              en_wr,
  output logic              stat_rd
);
  localparam int unsigned PAD_W = DATA_W - 1;

  logic              rv_q;
  logic [DATA_W-1:0] rd_q;
  logic              accept;
  reg_dec_t          dec;
  logic [DATA_W-1:0] rd_mux;

  assign req_ready = ~rv_q | rsp_ready;
  assign accept    = req_valid & req_ready;
  assign dec       = decode_off(int'(req_addr));

  assign state_wr = accept &  req_write & dec.hit & (dec.sel == SEL_STATE);
  assign en_wr    = accept &  req_write & dec.hit & (dec.sel == SEL_ENABLE);
  assign stat_rd  = accept & ~req_write & dec.hit & (dec.sel == SEL_STATUS);

  always_comb begin
    rd_mux = '0;
    if (dec.hit) begin
      unique case (dec.sel)
        SEL_STATE:  rd_mux = cur_state;
        SEL_FLAGS:  rd_mux = {{PAD_W{1'b0}}, flag_output};
        SEL_STATUS: rd_mux = {{PAD_W{1'b0}}, stat_bit};
        SEL_ENABLE: rd_mux = {{PAD_W{1'b0}}, en_bit};
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      rd_q <= '0;
    end else if (accept && !req_write) begin
      rv_q <= 1'b1;
      rd_q <= rd_mux;
    end else if (rsp_ready) begin
      rv_q <= 1'b0;
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_data  = rd_q;
endmodule

// File: rtl/sw_state_core.sv
module sw_state_core #(
  parameter int unsigned DATA_W    = 32,
  parameter bit          IS_OUTPUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_valid,
  input  logic [DATA_W-1:0] upd_state,
  input  logic              state_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              stat_rd,
  input  logic              en_q,
  output logic [DATA_W-1:0] state_q,
  output logic              pend_q,
  output logic              pend_nxt,
  output logic              err_q
);
  logic              sw_take;
  logic              sw_bad;
  logic [DATA_W-1:0] st_nxt;
  logic              err_nxt;

  generate
    if (IS_OUTPUT) begin : g_out
      assign sw_take = state_wr & (wdata != state_q);
      assign sw_bad  = 1'b0;
    end else begin : g_in
      assign sw_take = 1'b0;
      assign sw_bad  = state_wr;
    end
  endgenerate

  always_comb begin
    st_nxt   = state_q;
    pend_nxt = pend_q;
    err_nxt  = err_q | sw_bad;
    if (stat_rd && en_q && pend_q) pend_nxt = 1'b0;
    if (sw_take) begin
      st_nxt   = wdata;
      pend_nxt = 1'b1;
    end
    if (upd_valid) begin
      st_nxt   = upd_state;
      pend_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      pend_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= st_nxt;
      pend_q  <= pend_nxt;
      err_q   <= err_nxt;
    end
  end
endmodule

// File: rtl/sw_irq_ctl.sv
module sw_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic en_wr,
  input  logic en_wbit,
  input  logic pend_nxt,
  output logic en_q,
  output logic irq_q
);
  logic en_nxt;

  assign en_nxt = en_wr ? en_wbit : en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      en_q  <= en_nxt;
      irq_q <= pend_nxt & en_nxt;
    end
  end
endmodule

// File: rtl/switch_irq_reg.sv
module switch_irq_reg #(
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned DATA_W    = 32,
  parameter bit          IS_OUTPUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_valid,
  input  logic [DATA_W-1:0] upd_state,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic [DATA_W-1:0] state_o,
  output logic              irq,
  output logic              wr_fault
);
  logic state_wr, en_wr, stat_rd;
  logic pend_q, pend_nxt, en_q, err_q;
  logic [DATA_W-1:0] state_q;

  sw_bus_if #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .cur_state(state_q), .flag_output(IS_OUTPUT), .stat_bit(pend_q & en_q),
    .en_bit(en_q),
    .state_wr(state_wr), .en_wr(en_wr), .stat_rd(stat_rd)
  );

  sw_state_core #(.DATA_W(DATA_W), .IS_OUTPUT(IS_OUTPUT)) u_core (
    .clk(clk), .rst_n(rst_n),
    .upd_valid(upd_valid), .upd_state(upd_state),
    .state_wr(state_wr), .wdata(req_wdata), .stat_rd(stat_rd), .en_q(en_q),
    .state_q(state_q), .pend_q(pend_q), .pend_nxt(pend_nxt), .err_q(err_q)
  );

  sw_irq_ctl u_irq (
    .clk(clk), .rst_n(rst_n),
    .en_wr(en_wr), .en_wbit(req_wdata[0]), .pend_nxt(pend_nxt),
    .en_q(en_q), .irq_q(irq)
  );

  assign state_o  = state_q;
  assign wr_fault = err_q;
endmodule

// File: rtl/switch_irq_reg_chk.sv
module switch_irq_reg_chk #(
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned DATA_W    = 32,
  parameter bit          IS_OUTPUT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              upd_valid,
  input logic [DATA_W-1:0] upd_state,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic [DATA_W-1:0] state_o,
  input logic              irq,
  input logic              wr_fault,
  input logic              en_q,
  input logic              pend_q
);
  logic acc;
  assign acc = req_valid & req_ready;

  AST_UPD_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> (state_o == $past(upd_state)) && pend_q); // R2
  AST_UPD_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && en_q && !(acc && req_write && req_addr == 3)) |=> irq); // R2
  AST_EN_STEERS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && req_addr == 3 && pend_q && !upd_valid) |=> (irq == $past(req_wdata[0]))); // R4
  AST_STAT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && req_addr == 2 && irq && !upd_valid) |=> !irq && rsp_valid && rsp_data == 1); // R5
  AST_FLAGS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && req_addr == 1) |=> rsp_data == DATA_W'(IS_OUTPUT)); // R6
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fault |=> wr_fault); // R8
  AST_IN_STATE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!IS_OUTPUT && acc && req_write && req_addr == 0 && !upd_valid) |=> $stable(state_o) && wr_fault); // R8
  AST_UPD_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && acc && !req_write && req_addr == 2) |=> pend_q); // R9
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_data)); // R10
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready); // R10
  AST_RD_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write) |=> rsp_valid); // R10
endmodule

bind switch_irq_reg switch_irq_reg_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IS_OUTPUT(IS_OUTPUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_state(upd_state),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_data(rsp_data), .state_o(state_o), .irq(irq),
  .wr_fault(wr_fault), .en_q(en_q), .pend_q(pend_q)
);

// File: tb/sim_switch_irq_reg.sv
`timescale 1ns/1ps
module sim_switch_irq_reg;
  localparam int AW = 3;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd_valid = 1'b0;
  logic [DW-1:0] upd_state = '0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;

  logic          req_ready [2];
  logic          rsp_valid [2];
  logic [DW-1:0] rsp_data  [2];
  logic [DW-1:0] state_o   [2];
  logic          irq       [2];
  logic          wr_fault  [2];

  always #4 clk = ~clk; // 125 MHz

  switch_irq_reg #(.ADDR_W(AW), .DATA_W(DW), .IS_OUTPUT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_state(upd_state),
    .req_valid(req_valid), .req_ready(req_ready[0]), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid[0]),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data[0]), .state_o(state_o[0]),
    .irq(irq[0]), .wr_fault(wr_fault[0]));

  switch_irq_reg #(.ADDR_W(AW), .DATA_W(DW), .IS_OUTPUT(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_state(upd_state),
    .req_valid(req_valid), .req_ready(req_ready[1]), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid[1]),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data[1]), .state_o(state_o[1]),
    .irq(irq[1]), .wr_fault(wr_fault[1]));

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R1";

  // Reference model, one slot per instance (slot 0 output-built, slot 1 input-built)
  logic [DW-1:0] m_st [2];
  bit m_pend [2], m_en [2], m_err [2], m_rv [2];
  logic [DW-1:0] m_rd [2];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] model_read(input int i, input int a);
    case (a)
      0: return m_st[i];
      1: return (i == 0) ? 1 : 0;
      2: return (m_pend[i] && m_en[i]) ? 1 : 0;
      3: return m_en[i] ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_st[i] = '0; m_pend[i] = 0; m_en[i] = 0; m_err[i] = 0; m_rv[i] = 0; m_rd[i] = '0;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        bit acc;
        logic [DW-1:0] st_n;
        bit pend_n, en_n, err_n;
        acc = req_valid && (!m_rv[i] || rsp_ready);
        st_n = m_st[i]; pend_n = m_pend[i]; en_n = m_en[i]; err_n = m_err[i];
        if (m_rv[i] && rsp_ready) m_rv[i] = 0;
        if (acc && !req_write) begin
          m_rv[i] = 1;
          m_rd[i] = model_read(i, int'(req_addr));
          if (req_addr == 2 && m_pend[i] && m_en[i]) pend_n = 0;
        end
        if (acc && req_write) begin
          if (req_addr == 3) en_n = req_wdata[0];
          if (req_addr == 0) begin
            if (i == 1) err_n = 1;
            else if (req_wdata != m_st[i]) begin st_n = req_wdata; pend_n = 1; end
          end
        end
        if (upd_valid) begin st_n = upd_state; pend_n = 1; end
        m_st[i] = st_n; m_pend[i] = pend_n; m_en[i] = en_n; m_err[i] = err_n;
      end
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 2; i++) begin
        check(irq[i] == (m_pend[i] && m_en[i]), {cur_req, " irq"}, irq[i], m_pend[i] && m_en[i]);
        check(state_o[i] == m_st[i], {cur_req, " state"}, state_o[i], m_st[i]);
        check(wr_fault[i] == m_err[i], {cur_req, " fault"}, wr_fault[i], m_err[i]);
        check(rsp_valid[i] == m_rv[i], {cur_req, " rsp_valid"}, rsp_valid[i], m_rv[i]);
        check(req_ready[i] == (!m_rv[i] || rsp_ready), {cur_req, " req_ready"},
              req_ready[i], !m_rv[i] || rsp_ready);
        if (m_rv[i])
          check(rsp_data[i] == m_rd[i], {cur_req, " rsp_data"}, rsp_data[i], m_rd[i]);
      end
    end
  end

  logic [DW-1:0] rd0, rd1;

  task automatic bus(input bit wr, input int a, input logic [DW-1:0] d);
    @(posedge clk); #1;
    req_valid = 1; req_write = wr; req_addr = AW'(a); req_wdata = d;
    forever begin @(negedge clk); if (req_ready[0]) break; end
    @(posedge clk); #1;
    req_valid = 0; req_write = 0;
    @(negedge clk);
    rd0 = rsp_data[0]; rd1 = rsp_data[1];
  endtask

  task automatic hw_update(input logic [DW-1:0] v);
    @(posedge clk); #1;
    upd_valid = 1; upd_state = v;
    @(posedge clk); #1;
    upd_valid = 0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1 reset values
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      check(irq[i] == 0 && wr_fault[i] == 0 && state_o[i] == 0 && rsp_valid[i] == 0,
            "R1 reset outputs", {irq[i], wr_fault[i]}, 0);
    end
    @(posedge clk); #1 rst_n = 1;
    bus(0, 3, 0); check(rd0 == 0, "R1 enable after reset", rd0, 0);
    bus(0, 0, 0); check(rd0 == 0, "R1 state after reset", rd0, 0);

    cur_req = "R6";
    bus(0, 1, 0);
    check(rd0 == 1, "R6 flags output", rd0, 1);
    check(rd1 == 0, "R6 flags input", rd1, 0);

    cur_req = "R2";
    hw_update(32'h0000_00A5);
    check(state_o[0] == 32'hA5 && irq[0] == 0, "R2 update stored, irq masked", state_o[0], 32'hA5);

    cur_req = "R5";
    bus(0, 2, 0); check(rd0 == 0, "R5 status with enable clear", rd0, 0);

    cur_req = "R4";
    bus(1, 3, 1); @(negedge clk);
    check(irq[0] == 1, "R4 enable with change pending", irq[0], 1);
    cur_req = "R3";
    bus(1, 3, 32'h6); @(negedge clk);
    check(irq[0] == 0, "R3 R4 enable upper bits dropped", irq[0], 0);
    bus(0, 3, 0); check(rd0 == 0, "R3 enable readback", rd0, 0);
    bus(1, 3, 32'hFFFF_FFFF);
    bus(0, 3, 0); check(rd0 == 1, "R3 enable readback only bit0", rd0, 1);

    cur_req = "R5";
    bus(0, 2, 0); check(rd0 == 1, "R5 status ack", rd0, 1);
    @(negedge clk); check(irq[0] == 0, "R5 irq low after ack", irq[0], 0);
    bus(0, 2, 0); check(rd0 == 0, "R5 second status read", rd0, 0);

    cur_req = "R4";
    bus(1, 3, 0); bus(1, 3, 1); @(negedge clk);
    check(irq[0] == 0, "R4 enable with nothing pending", irq[0], 0);

    cur_req = "R2";
    hw_update(32'h0000_00A5);
    check(irq[0] == 1, "R2 same-value update raises irq", irq[0], 1);
    bus(0, 2, 0);

    cur_req = "R7";
    bus(1, 0, 32'h0000_00A5); @(negedge clk);
    check(irq[0] == 0, "R7 same-value state write", irq[0], 0);
    cur_req = "R8";
    check(wr_fault[1] == 1, "R8 input state write faults", wr_fault[1], 1);
    check(state_o[1] == 32'hA5, "R8 input state unchanged", state_o[1], 32'hA5);
    cur_req = "R7";
    bus(1, 0, 32'h1234_5678); @(negedge clk);
    check(state_o[0] == 32'h1234_5678 && irq[0] == 1, "R7 new state write", state_o[0], 32'h1234_5678);
    bus(0, 0, 0); check(rd0 == 32'h1234_5678, "R11 state readback", rd0, 32'h1234_5678);
    bus(0, 2, 0);

    cur_req = "R9";
    hw_update(32'h3);
    @(posedge clk); #1;
    req_valid = 1; req_write = 0; req_addr = 2; upd_valid = 1; upd_state = 32'h7;
    @(posedge clk); #1;
    req_valid = 0; upd_valid = 0;
    @(negedge clk);
    check(rsp_data[0] == 1, "R9 read reports old pending", rsp_data[0], 1);
    check(irq[0] == 1, "R9 update survives ack", irq[0], 1);
    bus(0, 2, 0);

    cur_req = "R10";
    @(posedge clk); #1;
    rsp_ready = 0; req_valid = 1; req_write = 0; req_addr = 0;
    @(posedge clk); #1;
    req_valid = 0;
    repeat (3) @(negedge clk);
    check(rsp_valid[0] == 1 && req_ready[0] == 0, "R10 stalled response held", rsp_valid[0], 1);
    check(rsp_data[0] == 32'h7, "R10 stalled data", rsp_data[0], 32'h7);
    @(posedge clk); #1 rsp_ready = 1;
    @(negedge clk); @(negedge clk);
    check(rsp_valid[0] == 0, "R10 response drained", rsp_valid[0], 0);

    cur_req = "R11";
    bus(1, 5, 32'hFFFF_FFFF);
    bus(0, 6, 0); check(rd0 == 0, "R11 unmapped read", rd0, 0);
    bus(0, 3, 0); check(rd0 == 1, "R11 unmapped write ignored", rd0, 1);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule